// File: doc/BRIEF.md
# Eight-bit ALU with truth flag

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle that `valid_i` is high, it takes a 5-bit operation code and two operands, A and B. It then does one of three things: produce a data result for a register write, compute a one-bit comparison into an internal truth register (TR), or set or clear TR directly. The decoder later uses TR to gate conditional instructions; that gating is not part of this block.

Outputs are registered and appear one clock after the operation is presented. `wr_o` tells the register file to capture `result_o`. `tr_o` always shows the current TR value. Comparisons are unsigned. Shift and rotate amounts come from the low bits of B. Add, subtract, increment and decrement wrap modulo 2^WIDTH.

Top module: `alu_tr`

## Requirements
- R1: Op codes 0, 1, 2 and 3 give A AND B, A OR B, A XOR B and NOT B on `result_o` the cycle after issue, with `wr_o` high.
- R2: Op 4 is a logical left shift of A and op 5 a logical right shift of A. Op 6 rotates A right and op 7 rotates A left. The amount is B modulo WIDTH (the low 3 bits of B when WIDTH is 8), and `wr_o` is high.
- R3: Ops 8 to 13 load TR with the unsigned tests A>B, A>=B, A<B, A<=B, A==B and A!=B, in that code order.
- R4: Op 14 loads TR with (A==0) and op 15 loads TR with (A!=0); B is ignored.
- R5: Op 16 sets TR to 1 and op 17 clears TR to 0.
- R6: Op 20 gives A+B and op 21 gives A-B. Op 19 gives A+1 and op 18 gives A-1. All wrap modulo 2^WIDTH, with `wr_o` high.
- R7: `wr_o` is high only in the cycle after a valid data op (codes 0-7 and 18-21). It is low after comparison, TR, undefined and idle cycles.
- R8: Undefined codes 22 to 31 produce no write and leave TR and `result_o` unchanged.
- R9: While `rst_ni` is low, TR is 0, `wr_o` is 0 and `result_o` is 0.
- R10: TR changes only after a valid comparison or TR op. Data ops and idle cycles leave it unchanged.
- R11: `result_o` holds its last written value whenever `wr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | Operand A (first source) |
| b_i | input | WIDTH | Operand B (second source) |
| result_o | output | WIDTH | Registered data result |
| wr_o | output | 1 | Register-write strobe for result_o |
| tr_o | output | 1 | Truth register value |

## Verification
The bench builds the block with its default WIDTH of 8. This gives a 3-bit shift amount, so B values of 8 and above exercise the modulo behaviour of R2. The 8-bit width also puts the wrap points 255+1 and 0-1 within reach of direct stimulus. Every one of the 32 codes is swept with varied operands, including the undefined ones. The sweep runs both with TR at 1 and with TR at 0, so that any unwanted change to TR shows on `tr_o`.

// File: rtl/alu_tr_pkg.sv
`timescale 1ns/1ps
package alu_tr_pkg;
  localparam logic [4:0] OP_AND  = 5'd0;
  localparam logic [4:0] OP_ROTL = 5'd7;
  localparam logic [4:0] OP_GT   = 5'd8;
  localparam logic [4:0] OP_NEZ  = 5'd15;
  localparam logic [4:0] OP_SETT = 5'd16;
  localparam logic [4:0] OP_CLRT = 5'd17;
  localparam logic [4:0] OP_DEC  = 5'd18;
  localparam logic [4:0] OP_SUB  = 5'd21;
  localparam logic [4:0] OP_EQZ  = 5'd14;
  localparam logic [4:0] OP_UNDEF_LO = 5'd22;
endpackage

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit #(
  parameter int WIDTH = 8,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [2:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [WIDTH-1:0] res_o
);
  logic [2*WIDTH-1:0] dbl, rot_r, rot_l;

  always_comb begin
    dbl   = {a_i, a_i};
    rot_r = dbl >> shamt_i;
    rot_l = dbl << shamt_i;
    case (sel_i)
      3'd0:    res_o = a_i & b_i;
      3'd1:    res_o = a_i | b_i;
      3'd2:    res_o = a_i ^ b_i;
      3'd3:    res_o = ~b_i;
      3'd4:    res_o = a_i << shamt_i;
      3'd5:    res_o = a_i >> shamt_i;
      3'd6:    res_o = rot_r[WIDTH-1:0];
      default: res_o = rot_l[2*WIDTH-1:WIDTH];
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       sel_i,  // 00 add, 01 sub, 10 dec, 11 inc
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] addend;
  logic             negate;

  // one adder shared by all four ops
  always_comb begin
    case (sel_i)
      2'b00:   begin addend = b_i;             negate = 1'b0; end
      2'b01:   begin addend = b_i;             negate = 1'b1; end
      2'b10:   begin addend = WIDTH'(1);       negate = 1'b1; end
      default: begin addend = WIDTH'(1);       negate = 1'b0; end
    endcase
    res_o = a_i + (negate ? ~addend : addend) + WIDTH'(negate);
  end
endmodule

// File: rtl/alu_cmp_unit.sv
`timescale 1ns/1ps
module alu_cmp_unit #(
  parameter int WIDTH = 8
) (
  input  logic [2:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             tr_o
);
  logic gt, eq, az;

  always_comb begin
    gt = a_i > b_i;
    eq = a_i == b_i;
    az = a_i == '0;
    case (sel_i)
      3'd0:    tr_o = gt;
      3'd1:    tr_o = gt | eq;
      3'd2:    tr_o = ~(gt | eq);
      3'd3:    tr_o = ~gt;
      3'd4:    tr_o = eq;
      3'd5:    tr_o = ~eq;
      3'd6:    tr_o = az;
      default: tr_o = ~az;
    endcase
  end
endmodule

// File: rtl/alu_tr.sv
`timescale 1ns/1ps
module alu_tr
  import alu_tr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_o,
  output logic             tr_o
);
  logic [WIDTH-1:0] logic_res, arith_res, res_d, res_q;
  logic             cmp_bit, wr_d, wr_q, tr_we, tr_d, tr_q;

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .sel_i(op_i[2:0]), .a_i(a_i), .b_i(b_i),
    .shamt_i(b_i[SHW-1:0]), .res_o(logic_res)
  );

  alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .sel_i(op_i[1:0]), .a_i(a_i), .b_i(b_i), .res_o(arith_res)
  );

  alu_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
    .sel_i(op_i[2:0]), .a_i(a_i), .b_i(b_i), .tr_o(cmp_bit)
  );

  always_comb begin
    wr_d  = 1'b0;
    res_d = res_q;
    tr_we = 1'b0;
    tr_d  = tr_q;
    if (valid_i) begin
      if (op_i <= OP_ROTL) begin
        wr_d = 1'b1; res_d = logic_res;
      end else if (op_i <= OP_NEZ) begin
        tr_we = 1'b1; tr_d = cmp_bit;
      end else if (op_i == OP_SETT || op_i == OP_CLRT) begin
        tr_we = 1'b1; tr_d = (op_i == OP_SETT);
      end else if (op_i >= OP_DEC && op_i <= OP_SUB) begin
        wr_d = 1'b1; res_d = arith_res;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      tr_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      wr_q  <= wr_d;
      if (tr_we) tr_q <= tr_d;
    end
  end

  assign result_o = res_q;
  assign wr_o     = wr_q;
  assign tr_o     = tr_q;

  a_r7_wr_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(valid_i));
  a_r10_tr_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(tr_o));
  a_r11_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> $stable(result_o));
  a_r5_set_tr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SETT) |=> tr_o);
  a_r5_clr_tr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CLRT) |=> !tr_o);
  a_r4_zero_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_EQZ) |=> (tr_o == ($past(a_i) == '0)));
  a_r8_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_UNDEF_LO) |=> (!wr_o && $stable(tr_o)));
  a_r3_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_GT && op_i <= OP_CLRT) |=> !wr_o);
endmodule

// File: tb/sim_alu_tr.sv
`timescale 1ns/1ps
module sim_alu_tr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] result;
  logic       wr, tr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic       wr;
    logic [7:0] res;
    logic       tr;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic       m_tr = 1'b0;
  logic [7:0] m_res = '0;

  always #4 clk = ~clk;

  alu_tr #(.WIDTH(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .result_o(result), .wr_o(wr), .tr_o(tr)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [4:0] o, input logic [7:0] x,
                       input logic [7:0] y, input string tag);
    exp_t e;
    logic [2:0] s;
    s = y[2:0];
    e.wr = 1'b0; e.res = m_res; e.tr = m_tr; e.tag = tag;
    @(negedge clk);
    valid = v; op = o; a = x; b = y;
    if (v) begin
      case (o)
        5'd0:  begin e.wr = 1; e.res = x & y; end
        5'd1:  begin e.wr = 1; e.res = x | y; end
        5'd2:  begin e.wr = 1; e.res = x ^ y; end
        5'd3:  begin e.wr = 1; e.res = ~y; end
        5'd4:  begin e.wr = 1; e.res = x << s; end
        5'd5:  begin e.wr = 1; e.res = x >> s; end
        5'd6:  begin e.wr = 1; e.res = 8'((16'(x) >> s) | (16'(x) << (8 - s))); end
        5'd7:  begin e.wr = 1; e.res = 8'((16'(x) << s) | (16'(x) >> (8 - s))); end
        5'd8:  e.tr = x > y;
        5'd9:  e.tr = x >= y;
        5'd10: e.tr = x < y;
        5'd11: e.tr = x <= y;
        5'd12: e.tr = x == y;
        5'd13: e.tr = x != y;
        5'd14: e.tr = x == 0;
        5'd15: e.tr = x != 0;
        5'd16: e.tr = 1'b1;
        5'd17: e.tr = 1'b0;
        5'd18: begin e.wr = 1; e.res = x - 8'd1; end
        5'd19: begin e.wr = 1; e.res = x + 8'd1; end
        5'd20: begin e.wr = 1; e.res = x + y; end
        5'd21: begin e.wr = 1; e.res = x - y; end
        default: ;
      endcase
    end
    m_res = e.res; m_tr = e.tr;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "wr", int'(wr), int'(e.wr));
      check(e.tag, "result", int'(result), int'(e.res));
      check(e.tag, "tr", int'(tr), int'(e.tr));
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset tr", int'(tr), 0);
    check("R9", "reset wr", int'(wr), 0);
    check("R9", "reset result", int'(result), 0);
    rst_n = 1'b1;

    // R1 bitwise
    issue(1, 5'd0, 8'hF0, 8'h3C, "R1");
    issue(1, 5'd1, 8'hF0, 8'h0F, "R1");
    issue(1, 5'd2, 8'hAA, 8'hFF, "R1");
    issue(1, 5'd3, 8'h12, 8'h5A, "R1");
    // R2 shifts and rotates, amount taken mod 8
    issue(1, 5'd4, 8'h81, 8'd3, "R2");
    issue(1, 5'd5, 8'h81, 8'd0, "R2");
    issue(1, 5'd5, 8'h80, 8'd9, "R2");
    issue(1, 5'd6, 8'h81, 8'd1, "R2");
    issue(1, 5'd7, 8'h81, 8'd1, "R2");
    issue(1, 5'd7, 8'hC3, 8'd12, "R2");
    // R3 unsigned compares, TR alternates
    issue(1, 5'd8, 8'hFF, 8'h01, "R3");
    issue(1, 5'd9, 8'h10, 8'h10, "R3");
    issue(1, 5'd10, 8'h10, 8'h10, "R3");
    issue(1, 5'd11, 8'h10, 8'h10, "R3");
    issue(1, 5'd10, 8'h01, 8'hFF, "R3");
    issue(1, 5'd12, 8'h33, 8'h34, "R3");
    issue(1, 5'd13, 8'h33, 8'h34, "R3");
    // R4 zero tests with B nonzero
    issue(1, 5'd14, 8'h00, 8'hFF, "R4");
    issue(1, 5'd15, 8'h00, 8'hFF, "R4");
    issue(1, 5'd15, 8'h80, 8'h00, "R4");
    // R5
    issue(1, 5'd17, 8'h00, 8'h00, "R5");
    issue(1, 5'd16, 8'h00, 8'h00, "R5");
    // R6 wrap points
    issue(1, 5'd19, 8'hFF, 8'h00, "R6");
    issue(1, 5'd18, 8'h00, 8'h00, "R6");
    issue(1, 5'd20, 8'hF0, 8'h20, "R6");
    issue(1, 5'd21, 8'h05, 8'h07, "R6");
    // R8 undefined codes with TR=1, R10 data op keeps TR
    issue(1, 5'd22, 8'hFF, 8'hFF, "R8");
    issue(1, 5'd31, 8'h00, 8'h00, "R8");
    issue(0, 5'd17, 8'h00, 8'h00, "R10");
    issue(0, 5'd0, 8'hFF, 8'hFF, "R11");
    // R7 sweep every code, TR=1 then TR=0
    for (int pass = 0; pass < 2; pass++) begin
      issue(1, pass == 0 ? 5'd16 : 5'd17, 8'h00, 8'h00, "R5");
      for (int i = 0; i < 32; i++)
        issue(1, 5'(i), 8'(i * 37 + pass * 91), 8'(i * 11 + 3), "R7");
    end
    issue(0, 5'd0, 8'h00, 8'h00, "R11");
    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule